// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host port with a valid/ready handshake and an external asynchronous static RAM organised as words with one active-low enable per byte lane. Each accepted request is a single-word read or write. The controller registers the address, the lane selects and the write data. It then plays out the active-low chip, output and write strobes for a fixed number of clock cycles, and it drives the shared data bus through separate out, in and output-enable signals.

All timing is counted in clock cycles that come from parameters, which are rounded up from the memory's nanosecond limits. The defaults suit a 100 MHz clock: a 4-cycle write pulse inside a 5-cycle write, a 5-cycle read access, and 2 cycles of bus turnaround after a read. A write always ends on the rising edge of the write strobe, while chip and lane enables stay low for at least one more cycle. When requests follow one another, chip enable stays low across the boundary. A request that selects no lane is accepted but never reaches the memory bus.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and every `mem_be_n` bit are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A write with a non-empty `req_lanes` drives `req_addr` and `req_wdata` onto the memory bus with `mem_ce_n` and `mem_we_n` low. `mem_be_n[i]` is low exactly when `req_lanes[i]` is 1, and lane i covers data bits 8i+7:8i. Only the selected lanes of the word change.
- R3: `mem_we_n` is low for exactly WR_PULSE cycles, starting at the acceptance edge. A write occupies WR_CYCLE cycles, so the next request is accepted WR_CYCLE cycles after it at the earliest.
- R4: `mem_dq_oe` is 1 only while `mem_we_n` and `mem_ce_n` are low and `mem_oe_n` is high. It is never 1 within BUS_TURN cycles after `mem_oe_n` rises.
- R5: When `mem_we_n` rises, `mem_ce_n` is still low and `mem_be_n` has not changed, so the write strobe ends every write.
- R6: A read with a non-empty `req_lanes` holds `mem_oe_n` low and `mem_we_n` high for RD_ACCESS cycles. It samples `mem_dq_in` at the end of the last of those cycles. It returns a one-cycle `rsp_valid` RD_ACCESS cycles after acceptance, with the unselected lanes of `rsp_data` forced to zero.
- R7: A read occupies RD_ACCESS+BUS_TURN cycles, and `mem_oe_n` stays high for the final BUS_TURN of them.
- R8: `req_ready` is low from the acceptance edge until the last cycle of the operation. A request offered in that last cycle is accepted at once, and `mem_ce_n` stays low across that boundary.
- R9: A request with `req_lanes` = 0 is accepted without any strobe on the memory bus and leaves `req_ready` high. A read of this kind returns `rsp_valid` with zero data in the cycle right after acceptance.
- R10: `mem_addr` stays unchanged for the whole of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_lanes | input | DATA_W/8 | Byte lanes selected, bit i = bits 8i+7:8i |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | DATA_W | Data received from memory |

## Verification
The bench builds the controller with a 4-bit address, a 3-cycle write pulse inside a 5-cycle write, a 4-cycle read access and a 2-cycle turnaround. With these values the whole 16-word space can be swept with every lane combination, for both writes and reads. The short pulse and recovery bring each timing boundary within a handful of cycles. The bench memory model returns garbage until output enable has been low for the full access time, which exposes early sampling. It also counts write-pulse lengths and watches for driver contention. Every request is issued back to back, so acceptance spacing is measured for each transition: write to read, read to write and empty to non-empty.

// File: rtl/sram_ctl_pkg.sv
// Shared types of the asynchronous SRAM controller.
// Assumes: nothing beyond the standard language.
package sram_ctl_pkg;

    // Phase of the operation that owns the memory bus
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_t;

endpackage

// File: rtl/sram_ctl_timer.sv
// Cycle counter for the current memory operation.
// Counts from zero after a clear and stops advancing while run is low.
// Assumes: the owner compares the count against its own limits.
module sram_ctl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);

    // Restart at an accepted operation, advance while one is in flight
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sram_ctl_lanes.sv
// Per-byte-lane logic: turns lane selects into active-low lane enables
// and zeroes unselected lanes of the read word.
// Assumes: DATA_W is a whole number of 8-bit lanes.
module sram_ctl_lanes #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic [LANES-1:0]  sel_new,
    input  logic [LANES-1:0]  sel_cur,
    input  logic [DATA_W-1:0] rd_raw,
    output logic [LANES-1:0]  be_n_new,
    output logic [DATA_W-1:0] rd_masked
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane enable is the inverse of the request's lane select
        assign be_n_new[i] = ~sel_new[i];
        // Read data of an unselected lane is replaced with zero
        assign rd_masked[8*i +: 8] = sel_cur[i] ? rd_raw[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_ctl.sv
// Synchronous controller for an asynchronous byte-lane SRAM.
// Accepts single-word requests over valid/ready and plays out the
// active-low strobe sequence with cycle counts set by parameters.
// Assumes: WR_CYCLE > WR_PULSE >= 1, RD_ACCESS >= 1, BUS_TURN >= 1;
// the memory releases the bus within BUS_TURN cycles of output enable
// going high; the caller rounds nanosecond limits up to cycles.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int WR_PULSE  = 4,
    parameter int WR_CYCLE  = 5,
    parameter int RD_ACCESS = 5,
    parameter int BUS_TURN  = 2,
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYCLE = RD_ACCESS + BUS_TURN;
    localparam int MAX_CYC  = (WR_CYCLE > RD_CYCLE) ? WR_CYCLE : RD_CYCLE;
    localparam int CNT_W    = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    localparam logic [CNT_W-1:0] WR_END_CNT  = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] WR_LAST_CNT = CNT_W'(WR_CYCLE - 1);
    localparam logic [CNT_W-1:0] RD_END_CNT  = CNT_W'(RD_ACCESS - 1);
    localparam logic [CNT_W-1:0] RD_LAST_CNT = CNT_W'(RD_CYCLE - 1);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [LANES-1:0]  cur_lanes;
    logic [LANES-1:0]  be_n_new;
    logic [DATA_W-1:0] rd_masked;
    logic              last_cyc;
    logic              accept;
    logic              start;

    // Final cycle of the operation in flight
    assign last_cyc = ((phase == PH_WRITE) && (cnt == WR_LAST_CNT)) ||
                      ((phase == PH_READ)  && (cnt == RD_LAST_CNT));
    // Host may hand over a request when idle or in the final cycle
    assign req_ready = (phase == PH_IDLE) || last_cyc;
    assign accept    = req_valid && req_ready;
    assign start     = accept && (|req_lanes);

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .run   (phase != PH_IDLE),
        .cnt   (cnt)
    );

    sram_ctl_lanes #(.DATA_W(DATA_W)) u_lanes (
        .sel_new   (req_lanes),
        .sel_cur   (cur_lanes),
        .rd_raw    (mem_dq_in),
        .be_n_new  (be_n_new),
        .rd_masked (rd_masked)
    );

    // Phase sequencing and registered memory-side strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            mem_addr   <= '0;
            mem_ce_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_be_n   <= '1;
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
            cur_lanes  <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && start) begin
                phase     <= req_we ? PH_WRITE : PH_READ;
                mem_addr  <= req_addr;
                mem_ce_n  <= 1'b0;
                mem_be_n  <= be_n_new;
                cur_lanes <= req_lanes;
                mem_oe_n  <= req_we;
                mem_we_n  <= ~req_we;
                mem_dq_oe <= req_we;
                if (req_we)
                    mem_dq_out <= req_wdata;
            end else if (accept) begin
                phase     <= PH_IDLE;
                mem_ce_n  <= 1'b1;
                mem_oe_n  <= 1'b1;
                mem_we_n  <= 1'b1;
                mem_be_n  <= '1;
                mem_dq_oe <= 1'b0;
                if (!req_we) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= '0;
                end
            end else begin
                case (phase)
                    PH_WRITE: begin
                        if (cnt == WR_END_CNT) begin
                            mem_we_n  <= 1'b1;
                            mem_dq_oe <= 1'b0;
                        end
                    end
                    PH_READ: begin
                        if (cnt == RD_END_CNT) begin
                            mem_oe_n  <= 1'b1;
                            rsp_valid <= 1'b1;
                            rsp_data  <= rd_masked;
                        end
                    end
                    default: ;
                endcase
                if (last_cyc) begin
                    phase    <= PH_IDLE;
                    mem_ce_n <= 1'b1;
                    mem_be_n <= '1;
                end
            end
        end
    end

endmodule

// File: rtl/sram_ctl_chk.sv
// Protocol checker for the SRAM controller, bound to every instance.
// Assumes: only the top-level ports are observed.
module sram_ctl_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int BUS_TURN = 2,
    localparam int LANES   = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_lanes,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              mem_dq_oe
);

    localparam int TW = $clog2(BUS_TURN + 2);
    logic [TW-1:0] oe_hi_cnt;

    // Cycles since output enable was last low, saturating at BUS_TURN
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_hi_cnt <= TW'(BUS_TURN);
        else if (!mem_oe_n)
            oe_hi_cnt <= '0;
        else if (oe_hi_cnt < TW'(BUS_TURN))
            oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end

    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n)); // R4

    AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_hi_cnt >= TW'(BUS_TURN))); // R4

    AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R6

    AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_be_n))); // R5

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n) && !$past(req_valid && req_ready))
            |-> $stable(mem_addr)); // R10

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (|req_lanes)) |=> (!req_ready && !mem_ce_n)); // R8

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(|req_lanes))
            |=> (mem_we_n && mem_oe_n && mem_ce_n && req_ready)); // R9

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BUS_TURN (BUS_TURN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_lanes (req_lanes),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_test.sv
// Bench for sram_ctl: small configuration, full address and lane sweep,
// bus-level memory model with timing bookkeeping.
module sram_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 16;
    localparam int WR_PULSE   = 3;
    localparam int WR_CYCLE   = 5;
    localparam int RD_ACCESS  = 4;
    localparam int BUS_TURN   = 2;
    localparam int WORDS      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [1:0]        req_lanes = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]        mem_be_n;
    logic [DATA_W-1:0] mem_dq_out;
    logic [DATA_W-1:0] mem_dq_in;

    sram_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_PULSE(WR_PULSE),
        .WR_CYCLE(WR_CYCLE), .RD_ACCESS(RD_ACCESS), .BUS_TURN(BUS_TURN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DATA_W-1:0] model_mem [WORDS];
    logic [DATA_W-1:0] ref_mem   [WORDS];
    int oe_low_cnt = 0;
    int oe_hi_cnt  = 100;
    int we_len     = 0;
    logic prev_we_n = 1'b1;
    logic [ADDR_W-1:0] w_addr = '0;
    logic [1:0]        w_be = '1;
    logic [DATA_W-1:0] w_data = '0;
    bit   got_data = 0;
    int drv_viol  = 0;
    int addr_viol = 0;

    // Memory drives read data only once the access time has passed
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            if (mem_ce_n || mem_oe_n || !mem_we_n)
                mem_dq_in[8*i +: 8] = 8'h5A;
            else if (mem_be_n[i])
                mem_dq_in[8*i +: 8] = 8'hEE;
            else if (oe_low_cnt < RD_ACCESS)
                mem_dq_in[8*i +: 8] = 8'hBD;
            else
                mem_dq_in[8*i +: 8] = model_mem[mem_addr][8*i +: 8];
        end
    end

    // Mid-cycle bus observer: write commit, pulse length, contention
    always @(negedge clk) begin
        if (rst_n) begin
            oe_low_cnt = mem_oe_n ? 0 : oe_low_cnt + 1;
            oe_hi_cnt  = mem_oe_n ? ((oe_hi_cnt < 100) ? oe_hi_cnt + 1 : 100) : 0;
            if (mem_dq_oe && (!mem_oe_n || mem_we_n || mem_ce_n || oe_hi_cnt <= BUS_TURN))
                drv_viol++;
            if (!mem_we_n && !mem_ce_n) begin
                if (we_len == 0) begin
                    w_addr = mem_addr;
                    w_be = mem_be_n;
                    got_data = 0;
                end
                if (mem_addr != w_addr) addr_viol++;
                if (mem_dq_oe) begin
                    w_data = mem_dq_out;
                    got_data = 1;
                end
                we_len++;
            end
            if (mem_we_n && !prev_we_n) begin
                check(we_len == WR_PULSE, "R3", "write pulse length", we_len, WR_PULSE);
                check(!mem_ce_n && mem_be_n == w_be, "R5", "enables at pulse end",
                      {mem_ce_n, mem_be_n}, {1'b0, w_be});
                check(got_data, "R2", "data driven in pulse", got_data, 1);
                for (int i = 0; i < 2; i++)
                    if (!w_be[i]) model_mem[w_addr][8*i +: 8] = w_data[8*i +: 8];
                we_len = 0;
            end
            prev_we_n = mem_we_n;
        end
    end

    // ---------------- response monitor ----------------
    logic [DATA_W-1:0] exp_data_q [$];
    int                exp_cyc_q  [$];
    string             exp_tag_q  [$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_data_q.size() == 0) begin
                check(0, "R6", "unexpected response", 1, 0);
            end else begin
                logic [DATA_W-1:0] ed;
                int ec;
                string et;
                ed = exp_data_q.pop_front();
                ec = exp_cyc_q.pop_front();
                et = exp_tag_q.pop_front();
                check(rsp_data == ed, et, "read data", rsp_data, ed);
                check(cyc == ec, et, "response cycle", cyc, ec);
            end
        end
    end

    // ---------------- request driver ----------------
    int prev_acc = -1;
    int prev_dur = 0;
    string prev_tag = "R8";

    task automatic do_op(input logic we, input int addr, input logic [DATA_W-1:0] wd,
                         input logic [1:0] ln);
        int c0;
        int acc;
        logic [DATA_W-1:0] mask;
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = addr[ADDR_W-1:0];
        req_wdata = wd;
        req_lanes = ln;
        while (!req_ready) @(negedge clk);
        c0 = cyc;
        @(posedge clk);
        acc  = c0 + 1;
        mask = {{8{ln[1]}}, {8{ln[0]}}};
        if (we) begin
            ref_mem[addr] = (ref_mem[addr] & ~mask) | (wd & mask);
        end else begin
            exp_data_q.push_back(ref_mem[addr] & mask);
            exp_cyc_q.push_back(acc + ((ln == 2'b00) ? 0 : RD_ACCESS));
            exp_tag_q.push_back((ln == 2'b00) ? "R9" : "R6");
        end
        if (prev_acc >= 0)
            check(acc - prev_acc == prev_dur, prev_tag, "acceptance spacing",
                  acc - prev_acc, prev_dur);
        prev_acc = acc;
        if (ln == 2'b00) begin
            prev_dur = 1;
            prev_tag = "R9";
        end else if (we) begin
            prev_dur = WR_CYCLE;
            prev_tag = "R3";
        end else begin
            prev_dur = RD_ACCESS + BUS_TURN;
            prev_tag = "R7";
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "R8", "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            model_mem[i] = '0;
            ref_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state while held and just after release
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n} == 5'b11111, "R1",
              "strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 5'b11111);
        check(!mem_dq_oe && !rsp_valid && req_ready, "R1", "drivers/ready in reset",
              {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe} == 6'b111110, "R1",
              "strobes after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe},
              6'b111110);

        // R2: full-word writes across the whole space
        for (int a = 0; a < WORDS; a++)
            do_op(1'b1, a, 16'hA5C3 ^ DATA_W'(a * 16'h1111), 2'b11);
        // R2: single-lane writes on every word
        for (int a = 0; a < WORDS; a++)
            for (int l = 1; l < 3; l++)
                do_op(1'b1, a, DATA_W'(16'h3C00 + a * 16'h0101 + l * 16'h1010), 2'(l));
        // R6, R9: reads with every lane combination
        for (int a = 0; a < WORDS; a++)
            for (int l = 0; l < 4; l++)
                do_op(1'b0, a, '0, 2'(l));
        // R9: empty write leaves the word intact
        do_op(1'b1, 0, 16'hFFFF, 2'b00);
        do_op(1'b0, 0, '0, 2'b11);
        // R8: interleaved write/read stream, including empty requests
        for (int a = 0; a < WORDS; a++) begin
            do_op(1'b1, a, DATA_W'(a * 16'h0F0F + 16'h1234), 2'b11);
            do_op(1'b0, a, '0, 2'b11);
            do_op(1'b0, a, '0, 2'b00);
            do_op(1'b1, a ^ 1, 16'h7E81, 2'b01);
            do_op(1'b0, a ^ 1, '0, 2'b01);
        end

        repeat (RD_ACCESS + BUS_TURN + 4) @(negedge clk);
        check(exp_data_q.size() == 0, "R6", "outstanding responses", exp_data_q.size(), 0);
        check(drv_viol == 0, "R4", "driver contention cycles", drv_viol, 0);
        check(addr_viol == 0, "R10", "address changes in pulse", addr_viol, 0);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R8",
              "bus quiet when idle", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        summary();
    end

endmodule